// File: doc/BRIEF.md
# Key-Locked Indexed Configuration Port

This block puts a large internal configuration register file behind two byte-wide host I/O addresses. The host writes a register number to the index port, then reads or writes the data port to reach that register. The index stays latched, so several data accesses in a row all go to the same register until the index port is written again.

A lock guards every data access. One entry of the indexed space, index 0x03, is the lock register. It is handled inside the port and is never passed to the back end. Writing the key byte 0xC5 to it opens the file. Writing any other byte to it closes the file. While the file is closed, the port still watches for the key, so a key write to the lock index is the only data access that has any effect. The port comes out of reset closed.

On the back end, the port drives a read address that is always the latched index, and it accepts the selected register's value combinationally. Writes that are permitted reach the register file as a registered one-cycle strobe, together with the captured index and byte.

Top module: `cfgport_keyed`

## Requirements
- R1: After reset the file is locked and the index register holds 0x00. A read of the index port returns 0x00 and a read of the data port returns 0xFF.
- R2: A host write to I/O address 0x22 loads the write byte into the index register. A host read of 0x22 returns the current index in the same cycle as the read strobe.
- R3: A data-port write (I/O address 0x23) of 0xC5 while the index is 0x03 unlocks the file, whether it was locked or unlocked before.
- R4: A data-port write of any byte other than 0xC5 while the index is 0x03 locks the file.
- R5: While the file is locked, data-port reads return 0xFF and data-port writes produce no back-end write strobe.
- R6: While the file is unlocked, a data-port read returns, in the same cycle as the read strobe, the back-end read data for the register at the latched index. The back-end read address equals the index register.
- R7: A permitted data-port write raises the back-end write strobe for exactly one cycle, in the cycle after the host write. In that cycle the back end sees the latched index and the written byte.
- R8: Data-port reads and writes leave the index register unchanged, so repeated data accesses target the same register.
- R9: A host read or write to any I/O address other than 0x22 and 0x23 changes neither the index nor the lock state. Such a read returns 0xFF.
- R10: Data-port writes while the index is 0x03 never produce a back-end write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 8 | Host I/O address |
| io_wdata | input | 8 | Host write byte |
| io_wr | input | 1 | Host write strobe, one cycle per write |
| io_rd | input | 1 | Host read strobe |
| io_rdata | output | 8 | Host read byte, valid while io_rd is high |
| cfg_raddr | output | 8 | Back-end read address (the latched index) |
| cfg_rdata | input | 8 | Back-end read data for cfg_raddr |
| cfg_wr | output | 1 | Back-end write strobe, one cycle |
| cfg_waddr | output | 8 | Back-end write address |
| cfg_wdata | output | 8 | Back-end write data |

## Verification
A wrong lock state shows at the ports on the very next data access. A wrongly open file returns register contents in place of 0xFF, or raises an extra write strobe one cycle after a host write. A wrongly closed file returns 0xFF where register data is expected. A corrupted index shows in the same cycle as a read of the index port. It also shows as a wrong back-end address on the next data read, or on the strobe that follows a data write. The bench sweeps every lock byte, every index and every foreign address against a byte-array model of the register file. This lets a single wrong transition be caught within a few cycles of the access that causes it.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

   // Which of the two host-visible ports an I/O address selects.
   typedef enum logic [1:0] {
      PORT_NONE  = 2'd0,
      PORT_INDEX = 2'd1,
      PORT_DATA  = 2'd2
   } port_sel_e;

   // Read-path variants selectable by parameter.
   localparam int READ_COMB = 0;
   localparam int READ_REG  = 1;

endpackage

// File: rtl/cfgport_addr_decode.sv
module cfgport_addr_decode
   import cfgport_pkg::*;
#(
   parameter int              ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] INDEX_PORT = 8'h22,
   parameter logic [ADDR_W-1:0] DATA_PORT  = 8'h23
) (
   input  logic [ADDR_W-1:0] addr,
   output port_sel_e         sel
);

   if (INDEX_PORT == DATA_PORT) begin : g_bad_ports
      $error("cfgport_addr_decode: index and data ports must differ");
   end

   always_comb begin
      if (addr == INDEX_PORT)     sel = PORT_INDEX;
      else if (addr == DATA_PORT) sel = PORT_DATA;
      else                        sel = PORT_NONE;
   end

endmodule

// File: rtl/cfgport_index_reg.sv
module cfgport_index_reg #(
   parameter int             IDX_W       = 8,
   parameter logic [IDX_W-1:0] RESET_INDEX = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] din,
   output logic [IDX_W-1:0] idx_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    idx_q <= RESET_INDEX;
      else if (load) idx_q <= din;
   end

   // R8 / R9: without an index-port write the index holds.
   a_r8_index_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(idx_q));

   // R2: an index-port write lands in the register.
   a_r2_index_loads: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (idx_q == $past(din)));

endmodule

// File: rtl/cfgport_lock_ctrl.sv
module cfgport_lock_ctrl #(
   parameter int             DATA_W     = 8,
   parameter int             IDX_W      = 8,
   parameter logic [IDX_W-1:0]  LOCK_INDEX = 8'h03,
   parameter logic [DATA_W-1:0] UNLOCK_KEY = 8'hC5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_wr,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic              lock_sel,
   output logic              open_q
);

   logic key_match;

   assign lock_sel  = (idx == LOCK_INDEX);
   assign key_match = (wdata == UNLOCK_KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    open_q <= 1'b0;
      else if (data_wr && lock_sel)  open_q <= key_match;
   end

   // R1: the file is closed in the first cycle out of reset.
   a_r1_locked_out_of_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !open_q);

   // R3: the key opens the file from any state.
   a_r3_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && idx == LOCK_INDEX && wdata == UNLOCK_KEY) |=> open_q);

   // R4: any other byte at the lock index closes the file.
   a_r4_other_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && idx == LOCK_INDEX && wdata != UNLOCK_KEY) |=> !open_q);

   // R5: the lock state changes only through the lock index.
   a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !(data_wr && idx == LOCK_INDEX) |=> $stable(open_q));

endmodule

// File: rtl/cfgport_keyed.sv
module cfgport_keyed
   import cfgport_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter int IDX_W       = 8,
   parameter logic [ADDR_W-1:0] INDEX_PORT  = 8'h22,
   parameter logic [ADDR_W-1:0] DATA_PORT   = 8'h23,
   parameter logic [IDX_W-1:0]  LOCK_INDEX  = 8'h03,
   parameter logic [DATA_W-1:0] UNLOCK_KEY  = 8'hC5,
   parameter logic [DATA_W-1:0] FLOAT_VALUE = 8'hFF,
   parameter logic [IDX_W-1:0]  RESET_INDEX = 8'h00,
   parameter int READ_MODE   = READ_COMB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [DATA_W-1:0] io_wdata,
   input  logic              io_wr,
   input  logic              io_rd,
   output logic [DATA_W-1:0] io_rdata,
   output logic [IDX_W-1:0]  cfg_raddr,
   input  logic [DATA_W-1:0] cfg_rdata,
   output logic              cfg_wr,
   output logic [IDX_W-1:0]  cfg_waddr,
   output logic [DATA_W-1:0] cfg_wdata
);

   localparam int FILE_DEPTH = 1 << IDX_W;

   if (IDX_W > DATA_W) begin : g_bad_idx
      $error("cfgport_keyed: index width exceeds data width");
   end
   if (FILE_DEPTH < 2) begin : g_bad_depth
      $error("cfgport_keyed: register file too small");
   end
   if (READ_MODE != READ_COMB && READ_MODE != READ_REG) begin : g_bad_mode
      $error("cfgport_keyed: unknown read mode");
   end

   port_sel_e         sel;
   logic [IDX_W-1:0]  idx_q;
   logic              open_q;
   logic              lock_sel;
   logic              idx_load;
   logic              data_wr;
   logic              wr_pass;
   logic [DATA_W-1:0] idx_ext;
   logic [DATA_W-1:0] rd_value;

   cfgport_addr_decode #(
      .ADDR_W     (ADDR_W),
      .INDEX_PORT (INDEX_PORT),
      .DATA_PORT  (DATA_PORT)
   ) u_decode (
      .addr (io_addr),
      .sel  (sel)
   );

   assign idx_load = io_wr && (sel == PORT_INDEX);
   assign data_wr  = io_wr && (sel == PORT_DATA);

   cfgport_index_reg #(
      .IDX_W       (IDX_W),
      .RESET_INDEX (RESET_INDEX)
   ) u_index (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (idx_load),
      .din   (io_wdata[IDX_W-1:0]),
      .idx_q (idx_q)
   );

   cfgport_lock_ctrl #(
      .DATA_W     (DATA_W),
      .IDX_W      (IDX_W),
      .LOCK_INDEX (LOCK_INDEX),
      .UNLOCK_KEY (UNLOCK_KEY)
   ) u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .data_wr  (data_wr),
      .idx      (idx_q),
      .wdata    (io_wdata),
      .lock_sel (lock_sel),
      .open_q   (open_q)
   );

   // Back-end write: forwarded only when open and not aimed at the lock.
   assign wr_pass   = data_wr && open_q && !lock_sel;
   assign cfg_raddr = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_wr    <= 1'b0;
         cfg_waddr <= '0;
         cfg_wdata <= '0;
      end else begin
         cfg_wr <= wr_pass;
         if (wr_pass) begin
            cfg_waddr <= idx_q;
            cfg_wdata <= io_wdata;
         end
      end
   end

   // Read path value.
   always_comb begin
      idx_ext = '0;
      idx_ext[IDX_W-1:0] = idx_q;
      unique case (sel)
         PORT_INDEX: rd_value = idx_ext;
         PORT_DATA:  rd_value = open_q ? cfg_rdata : FLOAT_VALUE;
         default:    rd_value = FLOAT_VALUE;
      endcase
   end

   if (READ_MODE == READ_COMB) begin : g_read_comb
      assign io_rdata = io_rd ? rd_value : FLOAT_VALUE;
   end else begin : g_read_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     io_rdata <= FLOAT_VALUE;
         else if (io_rd) io_rdata <= rd_value;
         else            io_rdata <= FLOAT_VALUE;
      end
   end

   // R5: a closed file passes no write to the back end.
   a_r5_no_write_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !open_q) |=> !cfg_wr);

   // R10: lock-index writes never reach the back end.
   a_r10_lock_not_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && idx_q == LOCK_INDEX) |=> !cfg_wr);

   // R7: every strobe follows a host data-port write by one cycle.
   a_r7_strobe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |-> $past(io_wr && io_addr == DATA_PORT));

   // R7: the strobe carries the index that was latched at the write.
   a_r7_strobe_address: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |-> (cfg_waddr == $past(idx_q)));

   // R5: a closed data read floats (combinational read only).
   a_r5_locked_read_floats: assert property (@(posedge clk) disable iff (!rst_n)
      (READ_MODE == READ_COMB && io_rd && !io_wr && io_addr == DATA_PORT && !open_q)
      |-> (io_rdata == FLOAT_VALUE));

endmodule

// File: tb/cfgport_keyed_bench.sv
module cfgport_keyed_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] io_addr = 8'h00;
   logic [7:0] io_wdata = 8'h00;
   logic       io_wr = 1'b0;
   logic       io_rd = 1'b0;
   logic [7:0] io_rdata;
   logic [7:0] cfg_raddr;
   logic [7:0] cfg_rdata;
   logic       cfg_wr;
   logic [7:0] cfg_waddr;
   logic [7:0] cfg_wdata;

   int n_checks = 0;
   int n_fail   = 0;
   int n_strobe = 0;

   logic [7:0] be_mem  [256];
   logic [7:0] exp_mem [256];

   always #4 clk = ~clk;   // 125 MHz

   cfgport_keyed u_cfgport_keyed (
      .clk       (clk),
      .rst_n     (rst_n),
      .io_addr   (io_addr),
      .io_wdata  (io_wdata),
      .io_wr     (io_wr),
      .io_rd     (io_rd),
      .io_rdata  (io_rdata),
      .cfg_raddr (cfg_raddr),
      .cfg_rdata (cfg_rdata),
      .cfg_wr    (cfg_wr),
      .cfg_waddr (cfg_waddr),
      .cfg_wdata (cfg_wdata)
   );

   // Back-end register file model.
   assign cfg_rdata = be_mem[cfg_raddr];
   always @(posedge clk) begin
      if (cfg_wr) begin
         be_mem[cfg_waddr] <= cfg_wdata;
         n_strobe <= n_strobe + 1;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0; io_addr = 8'h00;
      @(negedge clk);
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      #2;
      d = io_rdata;
      io_rd = 1'b0; io_addr = 8'h00;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #1_000_000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      int base;
      for (int i = 0; i < 256; i++) begin
         be_mem[i]  = 8'(i) ^ 8'h5A;
         exp_mem[i] = 8'(i) ^ 8'h5A;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1: reset state
      rd(8'h22, v); chk("R1 index after reset", v, 8'h00);
      rd(8'h23, v); chk("R1 locked data read", v, 8'hFF);

      // R2: index load and read-back
      wr(8'h22, 8'hA7); rd(8'h22, v); chk("R2 index read-back", v, 8'hA7);

      // R5: locked sweep over every index
      for (int i = 0; i < 256; i++) begin
         if (i == 3) continue;
         wr(8'h22, 8'(i));
         wr(8'h23, ~8'(i));
         rd(8'h23, v); chk("R5 locked read floats", v, 8'hFF);
      end
      chk("R5 no strobe while locked", n_strobe, 0);

      // R3: key unlocks
      wr(8'h22, 8'h03); wr(8'h23, 8'hC5);
      wr(8'h22, 8'h10); rd(8'h23, v); chk("R3 unlocked read", v, exp_mem[8'h10]);

      // R6/R7/R8: unlocked sweep
      for (int i = 0; i < 256; i++) begin
         if (i == 3) continue;
         wr(8'h22, 8'(i));
         chk("R6 read address", cfg_raddr, i);
         rd(8'h23, v); chk("R6 unlocked read before write", v, exp_mem[i]);
         exp_mem[i] = 8'(i * 7 + 1);
         wr(8'h23, exp_mem[i]);
         rd(8'h23, v); chk("R8 first read after write", v, exp_mem[i]);
         rd(8'h23, v); chk("R8 repeated read same register", v, exp_mem[i]);
         rd(8'h22, v); chk("R8 index unchanged by data access", v, i);
      end
      chk("R7 one strobe per permitted write", n_strobe, 255);

      // R10: key write while unlocked is not forwarded
      base = n_strobe;
      wr(8'h22, 8'h03); wr(8'h23, 8'hC5);
      chk("R10 lock write not forwarded", n_strobe, base);

      // R7: single-cycle strobe with latched index and data
      wr(8'h22, 8'h40);
      @(negedge clk);
      io_addr = 8'h23; io_wdata = 8'h99; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0; io_addr = 8'h00;
      chk("R7 strobe high", cfg_wr, 1);
      chk("R7 strobe address", cfg_waddr, 8'h40);
      chk("R7 strobe data", cfg_wdata, 8'h99);
      @(negedge clk);
      chk("R7 strobe one cycle", cfg_wr, 0);
      exp_mem[8'h40] = 8'h99;

      // R9: foreign addresses ignored (file unlocked, index 0x40)
      for (int a = 0; a < 256; a++) begin
         if (a == 8'h22 || a == 8'h23) continue;
         wr(8'(a), 8'h03);
         rd(8'(a), v); chk("R9 foreign read floats", v, 8'hFF);
      end
      rd(8'h22, v); chk("R9 index kept", v, 8'h40);
      rd(8'h23, v); chk("R9 still unlocked", v, 8'h99);

      // R3/R4: every byte at the lock index
      for (int k = 0; k < 256; k++) begin
         wr(8'h22, 8'h03); wr(8'h23, 8'hC5);
         wr(8'h22, 8'h03); wr(8'h23, 8'(k));
         wr(8'h22, 8'h10); rd(8'h23, v);
         if (k == 8'hC5) chk("R3 key keeps file open", v, exp_mem[8'h10]);
         else            chk("R4 other byte locks", v, 8'hFF);
      end

      // R9: key on a foreign address does not unlock
      wr(8'h22, 8'h03); wr(8'h21, 8'hC5); wr(8'h24, 8'hC5);
      wr(8'h22, 8'h10); rd(8'h23, v); chk("R9 foreign key ignored", v, 8'hFF);

      // R3: unlock again from locked
      wr(8'h22, 8'h03); wr(8'h23, 8'hC5);
      wr(8'h22, 8'h40); rd(8'h23, v); chk("R3 reopen", v, 8'h99);

      finish_run();
   end

endmodule